// File: doc/BRIEF.md
# MDIO Management Frame Master

This block lets on-chip logic read and write 16-bit PHY registers over the two-wire management link. It derives the management clock (MDC) from the system clock, drives the data line through a separate output and output-enable pair, and samples the returned line level on its own input.

A request is taken in one system-clock cycle while `ready` is high. It carries a direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The block then sends the whole management frame. For reads, it hands the line to the PHY at the right moment and checks whether a PHY answered. It finishes with a one-cycle `done` pulse that comes with the read result and the error flag. Each MDC phase lasts `DIV` system clocks. A full transaction always gives 64 MDC rising edges.

Top module: `mdio_master`

## Requirements
- R1: After a request is accepted, the first 32 MDC rising edges each see `mdio_oe`=1 and `mdio_o`=1.
- R2: On rising edges 32..45 the host drives, most significant bit first: start code 01, then the opcode (10 for a read, 01 for a write), then the 5-bit PHY address, then the 5-bit register address.
- R3: Each bit is set while MDC is low, held for a high phase of `DIV` clocks, and followed by a low phase. The data line and enable never change while MDC is high. Every transaction produces exactly 64 MDC rising edges.
- R4: On a write, edges 46..47 carry the turnaround pattern 10 and edges 48..63 carry the write data MSB first. `mdio_oe` stays 1 for the whole transaction.
- R5: On a read, `mdio_oe` is 0 for exactly the rising edges 46..63. It falls and returns only while MDC is low in both the current and the previous cycle, and it is 1 again when `done` is seen.
- R6: On a read, `mdio_i` is sampled just before rising edge 47, which comes after the first turnaround pulse. If that sample is 0, the 16 values sampled just before edges 48..63 are placed in `rd_data` MSB first, and `rd_err` is 0.
- R7: If the turnaround sample is 1, all 64 edges are still issued, `rd_data` keeps its previous value and `rd_err` is 1.
- R8: A request is accepted only while `ready` is 1. `req_valid` during a transaction has no effect on that transaction. `done` is high for exactly one cycle, and `ready` is already 1 in that cycle.
- R9: While idle, MDC is 0, `mdio_oe` is 1 and `mdio_o` is 1. After reset `ready`=1, `done`=0, `rd_data`=0 and `rd_err`=0.
- R10: A completed write or a successful read leaves `rd_err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last successfully read register value |
| rd_err | output | 1 | Last read found no PHY |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value driven by the host |
| mdio_oe | output | 1 | Host drives the data line when 1 |
| mdio_i | input | 1 | Sampled data line level |

## Verification
Completion and acceptance of the next request can fall in the same cycle: `done` rises in the very cycle that `ready` returns. The bench holds `req_valid` high from the middle of a read, with the fields already changed to a different write, right through the `done` pulse. It then checks three things: the first frame carried only the original read, the write frame that follows is complete and correct, and the read result from the first frame is not disturbed by the second. A PHY model driven by MDC edges answers reads or leaves the line pulled high, and it records every driven bit for comparison.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        ready,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        rd_err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CW       = $clog2(DIV + 1);
  localparam int NBITS    = 64;
  localparam int RLS_BIT  = 46;
  localparam int TA_BIT   = 47;
  localparam int DAT_BIT  = 48;

  logic [CW-1:0] divcnt;
  logic [1:0]    ph;
  logic [6:0]    bitcnt;
  logic [63:0]   frame;
  logic [15:0]   shreg;
  logic          busy, is_rd, err_q;

  wire       tick    = (divcnt == CW'(DIV - 1));
  wire [6:0] nxt_bit = bitcnt + 7'd1;

  assign ready  = !busy;
  assign mdio_o = frame[63];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      divcnt  <= '0;
      ph      <= 2'd0;
      bitcnt  <= '0;
      frame   <= '1;
      shreg   <= '0;
      is_rd   <= 1'b0;
      err_q   <= 1'b0;
      done    <= 1'b0;
      rd_data <= '0;
      rd_err  <= 1'b0;
      mdc     <= 1'b0;
      mdio_oe <= 1'b1;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy   <= 1'b1;
          divcnt <= '0;
          ph     <= 2'd0;
          bitcnt <= '0;
          is_rd  <= !req_write;
          err_q  <= 1'b0;
          frame  <= {32'hFFFF_FFFF, 2'b01, (req_write ? 2'b01 : 2'b10),
                     req_phy, req_reg, 2'b10, (req_write ? req_wdata : 16'hFFFF)};
        end
      end else begin
        divcnt <= tick ? '0 : divcnt + CW'(1);
        if (tick) begin
          case (ph)
            2'd0: begin
              if (bitcnt == 7'(NBITS)) begin
                busy <= 1'b0;
                done <= 1'b1;
                if (is_rd) begin
                  rd_err <= err_q;
                  if (!err_q) rd_data <= shreg;
                end else begin
                  rd_err <= 1'b0;
                end
              end else begin
                ph  <= 2'd1;
                mdc <= 1'b1;
                if (is_rd && bitcnt == 7'(TA_BIT)) err_q <= mdio_i;
                if (is_rd && bitcnt >= 7'(DAT_BIT)) shreg <= {shreg[14:0], mdio_i};
              end
            end
            2'd1: begin
              ph  <= 2'd2;
              mdc <= 1'b0;
            end
            default: begin
              ph      <= 2'd0;
              bitcnt  <= nxt_bit;
              frame   <= {frame[62:0], 1'b1};
              mdio_oe <= !(is_rd && nxt_bit >= 7'(RLS_BIT) && nxt_bit < 7'(NBITS));
            end
          endcase
        end
      end
    end
  end

  p_stable_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_dir_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe != $past(mdio_oe)) |-> (!mdc && !$past(mdc)));

  p_release_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mdio_oe |-> !ready);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ready);

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid) |=> !ready);

  p_idle_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!mdc && mdio_oe && mdio_o));
endmodule

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic ready, done, rd_err, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic mdio_i = 1'b1;

  int n_chk = 0, n_fail = 0;
  int edge_cnt = 0, start_edge = 0;
  logic [63:0] cap = '0, capoe = '0;
  logic phy_present = 1'b1;
  logic [15:0] phy_data = '0;
  logic [15:0] exp_rd = '0;
  logic exp_err = 1'b0;

  always #10 clk = ~clk;

  mdio_master #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .ready(ready), .done(done), .rd_data(rd_data), .rd_err(rd_err),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  function automatic logic phy_bit(int j);
    if (j == 47) return !phy_present;
    if (j >= 48 && j <= 63) return phy_present ? phy_data[63-j] : 1'b1;
    return 1'b1;
  endfunction

  always @(posedge mdc) begin
    int k;
    k = edge_cnt - start_edge;
    if (k >= 0 && k < 64) begin
      cap[63-k]   = mdio_o;
      capoe[63-k] = mdio_oe;
    end
    edge_cnt = edge_cnt + 1;
    mdio_i = phy_bit(k + 1);
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(done, "R8 done timeout", {63'd0, done}, 64'd1);
  endtask

  task automatic issue(input logic wr, input logic pres, input logic [4:0] p,
                       input logic [4:0] r, input logic [15:0] d);
    while (!ready) @(negedge clk);
    phy_present = pres;
    phy_data    = d;
    start_edge  = edge_cnt;
    req_valid = 1'b1; req_write = wr; req_phy = p; req_reg = r; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!ready, "R8 accept", {63'd0, ready}, 64'd0);
  endtask

  task automatic judge(input logic wr, input logic pres, input logic [4:0] p,
                       input logic [4:0] r, input logic [15:0] d);
    logic [63:0] ef;
    ef = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r, 2'b10, d};
    chk(edge_cnt - start_edge == 64, "R3 edge count", 64'(edge_cnt - start_edge), 64'd64);
    chk(cap[63:32] == 32'hFFFF_FFFF, "R1 preamble", {32'd0, cap[63:32]}, 64'hFFFF_FFFF);
    chk(cap[31:18] == ef[31:18], "R2 header", {50'd0, cap[31:18]}, {50'd0, ef[31:18]});
    if (wr) begin
      chk(cap[17:0] == ef[17:0], "R4 write ta+data", {46'd0, cap[17:0]}, {46'd0, ef[17:0]});
      chk(capoe == '1, "R4 drive", capoe, '1);
      exp_err = 1'b0;
    end else begin
      chk(capoe == 64'hFFFF_FFFF_FFFC_0000, "R5 release window", capoe, 64'hFFFF_FFFF_FFFC_0000);
      exp_err = !pres;
      if (pres) exp_rd = d;
    end
    chk(mdio_oe && !mdc, "R5 line returned", {62'd0, mdio_oe, mdc}, 64'd2);
    chk(ready, "R8 ready with done", {63'd0, ready}, 64'd1);
    chk(rd_err == exp_err, wr ? "R10 err cleared" : (pres ? "R6 err" : "R7 err"), {63'd0, rd_err}, {63'd0, exp_err});
    chk(rd_data == exp_rd, pres ? "R6 read data" : "R7 data kept", {48'd0, rd_data}, {48'd0, exp_rd});
  endtask

  localparam int NV = 8;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 1'b1, 5'd1,  5'd0,  16'hA5C3},
    {1'b0, 1'b1, 5'd1,  5'd2,  16'h1234},
    {1'b0, 1'b0, 5'd31, 5'd31, 16'hBEEF},
    {1'b1, 1'b1, 5'd0,  5'd31, 16'hFFFF},
    {1'b0, 1'b1, 5'd16, 5'd1,  16'h0000},
    {1'b0, 1'b1, 5'd5,  5'd10, 16'h8001},
    {1'b1, 1'b0, 5'd31, 5'd0,  16'h0000},
    {1'b0, 1'b1, 5'd0,  5'd0,  16'hFFFF}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(ready && !done && rd_data == 0 && !rd_err, "R9 reset outputs",
        {46'd0, ready, done, rd_err, rd_data}, {46'd0, 3'b100, 16'd0});
    chk(!mdc && mdio_oe && mdio_o, "R9 reset lines", {61'd0, mdc, mdio_oe, mdio_o}, 64'd3);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][27], VEC[i][26], VEC[i][25:21], VEC[i][20:16], VEC[i][15:0]);
      wait_done();
      judge(VEC[i][27], VEC[i][26], VEC[i][25:21], VEC[i][20:16], VEC[i][15:0]);
      @(negedge clk);
      chk(!done, "R8 done one cycle", {63'd0, done}, 64'd0);
      chk(!mdc && mdio_oe && mdio_o, "R9 idle lines", {61'd0, mdc, mdio_oe, mdio_o}, 64'd3);
    end

    // R8: request held through a read and across its done cycle
    issue(1'b0, 1'b1, 5'd9, 5'd4, 16'h5A0F);
    repeat (100) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_phy = 5'd3; req_reg = 5'd7; req_wdata = 16'hC33C;
    wait_done();
    judge(1'b0, 1'b1, 5'd9, 5'd4, 16'h5A0F);
    phy_present = 1'b1;
    phy_data    = 16'hC33C;
    start_edge  = edge_cnt;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!ready && !done, "R8 back-to-back accept", {62'd0, ready, done}, 64'd0);
    wait_done();
    judge(1'b1, 1'b1, 5'd3, 5'd7, 16'hC33C);

    // R7 after R6: failed read keeps the last good data
    issue(1'b0, 1'b0, 5'd2, 5'd3, 16'h0F0F);
    wait_done();
    judge(1'b0, 1'b0, 5'd2, 5'd3, 16'h0F0F);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule